// File: doc/BRIEF.md
# Slice Ring Controller

This block keeps track of a circular video stream buffer in shared memory. Firmware fills the buffer with raw picture data and the encoder drains it. Firmware sets up the buffer before streaming: its base address, its size in bytes, the slice length, and the memory address that receives the consumer index. While streaming, firmware moves a producer index forward by writing it. The block owns the consumer index. Each time a whole slice of unread data is present, the block hands one slice read request to the encoder's fetch path and moves the consumer index past that slice. It then publishes the new consumer index to memory through a single write request.

Interrupts are coalesced. The block fires one interrupt after a programmable number of published slices. If fewer slices have built up and no further slice is published for a programmable number of cycles, it fires one anyway. A count of one gives an interrupt per slice. The block also reports empty and full. The full rule keeps one slice of headroom, so full can never be mistaken for empty. A producer write that would overrun the unread data is dropped, and a sticky error flag records it.

Top module: `slr_ring_ctrl`

## Requirements
- R1: After reset the block shows `empty`=1, `full`=0, `overflow`=0, `irq`=0, no read or write request, and both indexes at 0.
- R2: A slice read request is raised only when at least `cfg_slice_len` bytes lie between the consumer and producer indexes, with wrap taken into account. Its address is `cfg_base` plus the consumer index and its length is `cfg_slice_len`. The request stays raised with a stable address until it is accepted.
- R3: When a read request is accepted, the consumer index advances by one slice. It wraps to 0 on reaching `cfg_size`, which firmware keeps a multiple of the slice length. The block then raises a write request carrying the new index to `cfg_wb_addr`, held stable until it is accepted.
- R4: `empty` is 1 exactly when the two indexes are equal. `full` is 1 exactly when moving the producer index forward by one slice, with wrap, would make it equal the consumer index.
- R5: A producer write is accepted only if the new index is below `cfg_size` and the resulting fill does not exceed `cfg_size - cfg_slice_len`. Any other write leaves the producer index unchanged and sets `overflow`, which stays set until reset.
- R6: `irq` is a one-cycle pulse. It fires when the count of published slices since the last pulse reaches `cfg_coal_cnt`. A value of 0 acts as 1, and 1 gives one pulse per slice.
- R7: If published slices are waiting for a pulse and no further slice is published for `cfg_idle_to` cycles, `irq` pulses and the count clears. A `cfg_idle_to` of 0 disables this timeout.
- R8: Only one slice is in flight at a time. No new read request is raised until the write request of the previous slice has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Buffer base address |
| cfg_size | input | IW | Buffer size in bytes |
| cfg_slice_len | input | IW | Slice length in bytes |
| cfg_wb_addr | input | AW | Memory address that receives the consumer index |
| cfg_coal_cnt | input | CW | Slices per interrupt (0 acts as 1) |
| cfg_idle_to | input | TW | Idle timeout in cycles (0 disables it) |
| prod_wr_en | input | 1 | Firmware writes the producer index |
| prod_wr_idx | input | IW | New producer index |
| rd_req_valid | output | 1 | Slice read request |
| rd_req_ready | input | 1 | Fetch path accepts the read request |
| rd_req_addr | output | AW | Slice start address |
| rd_req_len | output | IW | Slice length |
| wb_valid | output | 1 | Consumer index write request |
| wb_ready | input | 1 | Memory accepts the write request |
| wb_addr | output | AW | Write address |
| wb_data | output | IW | Published consumer index |
| empty | output | 1 | Buffer holds no unread data |
| full | output | 1 | One more slice would catch the consumer |
| overflow | output | 1 | Sticky flag for a rejected producer write |
| irq | output | 1 | Coalesced interrupt pulse |

## Verification
The bench advances the producer by part of a slice to show that no read starts before a whole slice is present. It then fills the ring across its end so that the reads wrap from the last slice back to the base address. A design with the wrong remainder arithmetic would read past the end or stall. With the fetch path stalled, the bench makes a write that would overrun the consumer. A design that accepted it would fetch a fourth slice of stale data. Interrupt coalescing is checked with a count of three, with a count of two and the timeout disabled, and with a timeout shorter than the count. These catch a design that signals every slice, never times out, or times out while disabled.

// File: rtl/slr_pkg.sv
`timescale 1ns/1ps
package slr_pkg;

  // Slice sequencing: wait for data, offer the read, publish the index.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WB   = 2'd2
  } slr_state_e;

endpackage

// File: rtl/slr_prod_reg.sv
`timescale 1ns/1ps
module slr_prod_reg #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cfg_size,
  input  logic [IW-1:0] cfg_slice_len,
  input  logic [IW-1:0] cons_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  output logic [IW-1:0] prod_idx,
  output logic          overflow
);

  localparam int XW = IW + 1;

  logic [IW-1:0] prod_q, prod_d;
  logic          ovf_q, ovf_d;
  logic          prod_en, ovf_en;
  logic [XW-1:0] adv, fill, cap, fill_new;
  logic          in_range, fits, accept;

  always_comb begin
    if (wr_idx >= prod_q) adv = {1'b0, wr_idx} - {1'b0, prod_q};
    else                  adv = {1'b0, wr_idx} + {1'b0, cfg_size} - {1'b0, prod_q};
    if (prod_q >= cons_idx) fill = {1'b0, prod_q} - {1'b0, cons_idx};
    else                    fill = {1'b0, prod_q} + {1'b0, cfg_size} - {1'b0, cons_idx};
    cap      = {1'b0, cfg_size} - {1'b0, cfg_slice_len};
    fill_new = fill + adv;
    in_range = (wr_idx < cfg_size);
    fits     = (fill_new <= cap);
    accept   = in_range && fits;
    prod_en  = wr_en && accept;
    prod_d   = wr_idx;
    ovf_en   = wr_en && !accept;
    ovf_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (prod_en) prod_q <= prod_d;
      if (ovf_en)  ovf_q  <= ovf_d;
    end
  end

  assign prod_idx = prod_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/slr_cons_fsm.sv
`timescale 1ns/1ps
module slr_cons_fsm
  import slr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_size,
  input  logic [IW-1:0] cfg_slice_len,
  input  logic [AW-1:0] cfg_wb_addr,
  input  logic [IW-1:0] prod_idx,
  input  logic          rd_req_ready,
  input  logic          wb_ready,
  output logic [IW-1:0] cons_idx,
  output logic          rd_req_valid,
  output logic [AW-1:0] rd_req_addr,
  output logic [IW-1:0] rd_req_len,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [IW-1:0] wb_data,
  output logic          slice_done,
  output logic          empty,
  output logic          full
);

  localparam int XW = IW + 1;

  function automatic logic [IW-1:0] ring_add(input logic [IW-1:0] a,
                                             input logic [IW-1:0] b,
                                             input logic [IW-1:0] sz);
    logic [XW-1:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, sz}) s = s - {1'b0, sz};
    return s[IW-1:0];
  endfunction

  slr_state_e    st_q, st_d;
  logic [IW-1:0] cons_q, cons_d;
  logic          cons_en;
  logic [XW-1:0] avail;
  logic          have_slice;
  logic [IW-1:0] prod_next;

  always_comb begin
    if (prod_idx >= cons_q) avail = {1'b0, prod_idx} - {1'b0, cons_q};
    else                    avail = {1'b0, prod_idx} + {1'b0, cfg_size} - {1'b0, cons_q};
    have_slice = (cfg_slice_len != '0) && (avail >= {1'b0, cfg_slice_len});
    prod_next  = ring_add(prod_idx, cfg_slice_len, cfg_size);
  end

  always_comb begin
    st_d       = st_q;
    cons_d     = ring_add(cons_q, cfg_slice_len, cfg_size);
    cons_en    = 1'b0;
    slice_done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (have_slice) st_d = ST_REQ;
      ST_REQ: if (rd_req_ready) begin
        cons_en = 1'b1;
        st_d    = ST_WB;
      end
      ST_WB: if (wb_ready) begin
        slice_done = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cons_q <= '0;
    end else begin
      st_q <= st_d;
      if (cons_en) cons_q <= cons_d;
    end
  end

  assign cons_idx     = cons_q;
  assign rd_req_valid = (st_q == ST_REQ);
  assign rd_req_addr  = cfg_base + AW'(cons_q);
  assign rd_req_len   = cfg_slice_len;
  assign wb_valid     = (st_q == ST_WB);
  assign wb_addr      = cfg_wb_addr;
  assign wb_data      = cons_q;
  assign empty        = (prod_idx == cons_q);
  assign full         = (prod_next == cons_q);

endmodule

// File: rtl/slr_irq_mod.sv
`timescale 1ns/1ps
module slr_irq_mod #(
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slice_done,
  input  logic [CW-1:0] cfg_coal_cnt,
  input  logic [TW-1:0] cfg_idle_to,
  output logic          irq
);

  logic [CW-1:0] pend_q, pend_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          irq_q, irq_d;
  logic          pend_en, tmr_en;
  logic [CW-1:0] coal_eff;
  logic [CW:0]   pend_inc;
  logic [TW:0]   tmr_inc;

  always_comb begin
    coal_eff = (cfg_coal_cnt == '0) ? CW'(1) : cfg_coal_cnt;
    pend_inc = {1'b0, pend_q} + 1'b1;
    tmr_inc  = {1'b0, tmr_q} + 1'b1;
    pend_d   = pend_q;
    tmr_d    = tmr_q;
    irq_d    = 1'b0;
    pend_en  = 1'b0;
    tmr_en   = 1'b0;
    if (slice_done) begin
      pend_en = 1'b1;
      tmr_en  = 1'b1;
      tmr_d   = '0;
      if (pend_inc >= {1'b0, coal_eff}) begin
        irq_d  = 1'b1;
        pend_d = '0;
      end else begin
        pend_d = pend_inc[CW-1:0];
      end
    end else if ((pend_q != '0) && (cfg_idle_to != '0)) begin
      tmr_en = 1'b1;
      if (tmr_inc >= {1'b0, cfg_idle_to}) begin
        irq_d   = 1'b1;
        pend_en = 1'b1;
        pend_d  = '0;
        tmr_d   = '0;
      end else begin
        tmr_d = tmr_inc[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tmr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (pend_en) pend_q <= pend_d;
      if (tmr_en)  tmr_q  <= tmr_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/slr_ring_ctrl.sv
`timescale 1ns/1ps
module slr_ring_ctrl #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_size,
  input  logic [IW-1:0] cfg_slice_len,
  input  logic [AW-1:0] cfg_wb_addr,
  input  logic [CW-1:0] cfg_coal_cnt,
  input  logic [TW-1:0] cfg_idle_to,
  input  logic          prod_wr_en,
  input  logic [IW-1:0] prod_wr_idx,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic [IW-1:0] rd_req_len,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_addr,
  output logic [IW-1:0] wb_data,
  output logic          empty,
  output logic          full,
  output logic          overflow,
  output logic          irq
);

  logic [IW-1:0] prod_idx;
  logic [IW-1:0] cons_idx;
  logic          slice_done;

  slr_prod_reg #(.IW(IW)) i_prod (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_size      (cfg_size),
    .cfg_slice_len (cfg_slice_len),
    .cons_idx      (cons_idx),
    .wr_en         (prod_wr_en),
    .wr_idx        (prod_wr_idx),
    .prod_idx      (prod_idx),
    .overflow      (overflow)
  );

  slr_cons_fsm #(.AW(AW), .IW(IW)) i_cons (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_base      (cfg_base),
    .cfg_size      (cfg_size),
    .cfg_slice_len (cfg_slice_len),
    .cfg_wb_addr   (cfg_wb_addr),
    .prod_idx      (prod_idx),
    .rd_req_ready  (rd_req_ready),
    .wb_ready      (wb_ready),
    .cons_idx      (cons_idx),
    .rd_req_valid  (rd_req_valid),
    .rd_req_addr   (rd_req_addr),
    .rd_req_len    (rd_req_len),
    .wb_valid      (wb_valid),
    .wb_addr       (wb_addr),
    .wb_data       (wb_data),
    .slice_done    (slice_done),
    .empty         (empty),
    .full          (full)
  );

  slr_irq_mod #(.CW(CW), .TW(TW)) i_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .slice_done   (slice_done),
    .cfg_coal_cnt (cfg_coal_cnt),
    .cfg_idle_to  (cfg_idle_to),
    .irq          (irq)
  );

endmodule

// File: rtl/slr_ring_chk.sv
`timescale 1ns/1ps
module slr_ring_chk #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [IW-1:0] wb_data,
  input logic          empty,
  input logic          full,
  input logic          overflow,
  input logic          irq
);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r2_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !empty);

  a_r3_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> wb_valid);

  a_r3_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data));

  a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_one_at_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wb_valid));

endmodule

bind slr_ring_ctrl slr_ring_chk #(.AW(AW), .IW(IW)) i_chk (.*);

// File: tb/test_slr_ring_ctrl.sv
`timescale 1ns/1ps
module test_slr_ring_ctrl;

  localparam int AW = 32;
  localparam int IW = 16;
  localparam int CW = 8;
  localparam int TW = 16;
  localparam logic [AW-1:0] BASE = 32'h1000_0000;
  localparam logic [AW-1:0] WBA  = 32'h2000_0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = BASE;
  logic [IW-1:0] cfg_size = 16'd64;
  logic [IW-1:0] cfg_slice_len = 16'd16;
  logic [AW-1:0] cfg_wb_addr = WBA;
  logic [CW-1:0] cfg_coal_cnt = 8'd1;
  logic [TW-1:0] cfg_idle_to = 16'd0;
  logic          prod_wr_en = 1'b0;
  logic [IW-1:0] prod_wr_idx = '0;
  logic          rd_req_valid, rd_req_ready = 1'b1;
  logic [AW-1:0] rd_req_addr;
  logic [IW-1:0] rd_req_len;
  logic          wb_valid, wb_ready = 1'b1;
  logic [AW-1:0] wb_addr;
  logic [IW-1:0] wb_data;
  logic          empty, full, overflow, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int rd_cnt = 0, wb_cnt = 0, irq_cnt = 0;
  logic [AW-1:0] rd_log [0:63];
  logic [IW-1:0] wb_log [0:63];
  logic [AW-1:0] last_wb_addr = '0;

  always #4 clk = ~clk;

  slr_ring_ctrl #(.AW(AW), .IW(IW), .CW(CW), .TW(TW)) i_slr_ring_ctrl (.*);

  always @(posedge clk) begin
    if (rst_n) begin
      if (rd_req_valid && rd_req_ready) begin
        rd_log[rd_cnt[5:0]] <= rd_req_addr;
        rd_cnt <= rd_cnt + 1;
      end
      if (wb_valid && wb_ready) begin
        wb_log[wb_cnt[5:0]] <= wb_data;
        last_wb_addr <= wb_addr;
        wb_cnt <= wb_cnt + 1;
      end
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prod_write(input logic [IW-1:0] idx);
    @(negedge clk);
    prod_wr_en  = 1'b1;
    prod_wr_idx = idx;
    @(negedge clk);
    prod_wr_en  = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_req_valid", 32'(rd_req_valid), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
  endtask

  task automatic t_first_slice;
    int r0, w0, i0;
    r0 = rd_cnt; w0 = wb_cnt; i0 = irq_cnt;
    rd_req_ready = 1'b0;
    prod_write(16);
    cyc(4);
    chk("R2 request raised", 32'(rd_req_valid), 1);
    chk("R2 request addr", rd_req_addr, BASE);
    chk("R2 request len", 32'(rd_req_len), 16);
    chk("R8 no write while reading", 32'(wb_valid), 0);
    cyc(3);
    chk("R2 request held", 32'(rd_req_valid), 1);
    chk("R2 addr held", rd_req_addr, BASE);
    rd_req_ready = 1'b1;
    cyc(10);
    chk("R3 one read", 32'(rd_cnt - r0), 1);
    chk("R3 one write", 32'(wb_cnt - w0), 1);
    chk("R3 write data", 32'(wb_log[w0[5:0]]), 16);
    chk("R3 write addr", last_wb_addr, WBA);
    chk("R4 empty after drain", 32'(empty), 1);
    chk("R6 irq per slice", 32'(irq_cnt - i0), 1);
  endtask

  task automatic t_partial;
    int r0;
    r0 = rd_cnt;
    prod_write(24);
    cyc(10);
    chk("R2 no read on partial slice", 32'(rd_cnt - r0), 0);
    chk("R4 not empty", 32'(empty), 0);
    prod_write(32);
    cyc(10);
    chk("R2 read once slice complete", 32'(rd_cnt - r0), 1);
    chk("R2 second slice addr", rd_log[r0[5:0]], BASE + 32'd16);
    chk("R3 published index", 32'(wb_log[(wb_cnt - 1) & 63]), 32);
  endtask

  task automatic t_wrap_full;
    int r0, w0, i0;
    r0 = rd_cnt; w0 = wb_cnt; i0 = irq_cnt;
    rd_req_ready = 1'b0;
    prod_write(16);
    cyc(4);
    chk("R4 full at one slice headroom", 32'(full), 1);
    chk("R4 full not empty", 32'(empty), 0);
    chk("R5 legal fill no overflow", 32'(overflow), 0);
    prod_write(32);
    cyc(2);
    chk("R5 overrun sets overflow", 32'(overflow), 1);
    chk("R5 producer unchanged", 32'(full), 1);
    prod_write(70);
    cyc(2);
    chk("R5 out of range ignored", 32'(full), 1);
    rd_req_ready = 1'b1;
    cyc(30);
    chk("R5 only three slices fetched", 32'(rd_cnt - r0), 3);
    chk("R2 wrap addr a", rd_log[(r0 + 0) & 63], BASE + 32'd32);
    chk("R2 wrap addr b", rd_log[(r0 + 1) & 63], BASE + 32'd48);
    chk("R3 wrap addr to base", rd_log[(r0 + 2) & 63], BASE);
    chk("R3 wrapped index zero", 32'(wb_log[(w0 + 1) & 63]), 0);
    chk("R3 final index", 32'(wb_log[(w0 + 2) & 63]), 16);
    chk("R4 empty after wrap", 32'(empty), 1);
    chk("R6 three pulses", 32'(irq_cnt - i0), 3);
  endtask

  task automatic t_coalesce;
    int r0, i0;
    cfg_coal_cnt = 8'd3;
    cfg_idle_to  = 16'd0;
    r0 = rd_cnt; i0 = irq_cnt;
    prod_write(0);
    cyc(30);
    chk("R6 three slices read", 32'(rd_cnt - r0), 3);
    chk("R6 one pulse for three", 32'(irq_cnt - i0), 1);
    cfg_coal_cnt = 8'd2;
    i0 = irq_cnt;
    prod_write(16);
    cyc(100);
    chk("R7 timeout disabled no pulse", 32'(irq_cnt - i0), 0);
    prod_write(32);
    cyc(20);
    chk("R6 pulse on second slice", 32'(irq_cnt - i0), 1);
  endtask

  task automatic t_idle;
    int w0, i0, k;
    cfg_coal_cnt = 8'd4;
    cfg_idle_to  = 16'd20;
    w0 = wb_cnt; i0 = irq_cnt;
    prod_write(48);
    k = 0;
    while (wb_cnt == w0 && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk("R7 slice published", 32'(wb_cnt - w0), 1);
    cyc(5);
    chk("R7 no early pulse", 32'(irq_cnt - i0), 0);
    cyc(40);
    chk("R7 idle pulse", 32'(irq_cnt - i0), 1);
    chk("R5 overflow still set", 32'(overflow), 1);
  endtask

  initial begin
    cyc(3);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    t_reset;
    t_first_slice;
    t_partial;
    t_wrap_full;
    t_coalesce;
    t_idle;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule